// File: doc/BRIEF.md
# Audio Decoder Status Port Controller

This block presents the status of an audio decoder core on a 20-line parallel port that a host controller or nearby hardware can read. After reset the port lines float. Once the decoder reports that its start-up configuration is complete, the block switches into host mode and stays there. In host mode it drives the port lines for as long as the host holds the request line high and the select line low.

The port word carries several fields. There is a live input-data demand flag. When a frame's header has been decoded, the block captures the MPEG version index, the layer, the CRC result, the sampling-frequency code and the de-emphasis code together. The word also carries a sticky frame-sync flag. A header completion sets the flag, and its rising edge can serve as a host interrupt. The flag clears only when the host's read-control-data command is recognised.

A response-time monitor counts clock cycles from the moment the flag is set. If the read command has not arrived within a programmable half-frame count, it raises a one-cycle late-read pulse. An overrun bit records a new header completion that arrives while the previous event is still unread.

Top module: `dec_status_port`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `port_oe_o`, `port_o`, `late_rd_o` and `overrun_o` are all 0, and the frame-sync flag is clear.
- R2: `port_oe_o` is 1 only when all of the following hold:
  - `cfg_done_i` has been sampled high on some clock edge since reset, and this host mode is sticky;
  - `req_i` is currently 1;
  - `cs_n_i` is currently 0.

  When `port_oe_o` is 0, every bit of `port_o` is 0.
- R3: The bit layout of the driven word is as follows:
  - bit 19: demand flag (1 = input data requested).
  - bits 18:17: MPEG index (11 = MPEG 1, 10 = MPEG 2, 01 = reserved, 00 = MPEG 2.5).
  - bits 13:12: layer (11 = Layer 1, 10 = Layer 2, 01 = Layer 3, 00 = reserved).
  - bit 8: CRC error (1 = failed).
  - bit 4: frame-sync flag.
  - bits 3:2: sampling-frequency code (00 = 44.1 kHz family, 01 = 48 kHz family, 10 = 32 kHz family, 11 = reserved).
  - bits 1:0: de-emphasis (00 = none, 01 = 50/15 us, 10 = reserved, 11 = CCITT J.17).
- R4: The index, layer, CRC, sampling-frequency and de-emphasis fields are captured together on the clock edge where `hdr_done_i` is 1. They appear on the port in the following cycle and hold until the next such edge, whatever the field inputs do in between.
- R5: Bit 19 follows `demand_i` with one clock edge of latency, independent of `hdr_done_i`.
- R6: The frame-sync flag (bit 4) becomes 1 on the edge where `hdr_done_i` is 1. It becomes 0 on an edge where `rd_cmd_i` is 1 and `hdr_done_i` is 0. If both are 1 on the same edge, the flag ends up 1.
- R7: If the flag is set on edge E0 and no read command is sampled on edges E1 to E`half_frame_i`, then `late_rd_o` is 1 for exactly the one cycle following edge E`half_frame_i`.
- R8: A read command sampled on any of the edges E1 to E`half_frame_i` after the flag was set suppresses the late-read pulse for that event.
- R9: `overrun_o` becomes 1 on an edge where `hdr_done_i` is 1, the flag is already set and `rd_cmd_i` is 0. It stays 1 until an edge where `rd_cmd_i` is 1. A simultaneous header completion and read do not set it.
- R10: Port bits 16:14, 11:9 and 7:5 are always driven as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_done_i | input | 1 | Start-up configuration complete |
| req_i | input | 1 | Host request line, active high |
| cs_n_i | input | 1 | Host select line, active low |
| hdr_done_i | input | 1 | One-cycle strobe: frame header decoded |
| demand_i | input | 1 | Decoder wants more input data |
| mpeg_idx_i | input | 2 | MPEG version index of the decoded header |
| layer_i | input | 2 | Layer code of the decoded header |
| crc_err_i | input | 1 | CRC check failed for the frame |
| sfreq_i | input | 2 | Sampling-frequency code |
| deemph_i | input | 2 | De-emphasis code |
| rd_cmd_i | input | 1 | One-cycle strobe: read-control-data command recognised |
| half_frame_i | input | 24 | Allowed response time in clock cycles (at least 1) |
| port_o | output | 20 | Status port data |
| port_oe_o | output | 1 | Port output enable (0 = high impedance) |
| late_rd_o | output | 1 | One-cycle pulse: host read was late |
| overrun_o | output | 1 | Sticky: a frame event was overwritten unread |

## Verification
Several properties are checked on every cycle. The enable implies request high and select low, and a disabled or reserved bit is never driven. The flag follows a header strobe and a plain read. The captured fields are held while no header strobe arrives. The late pulse lasts one cycle and only occurs while the flag is set, and an unread header repeat leads to overrun. The exact cycle count to the late pulse, on-time reads at the window edge, the stickiness of host mode and the decoding of distinct field patterns into port bits can only be shown by the bench's directed scenarios.

// File: rtl/dec_status_pkg.sv
package dec_status_pkg;

    localparam int PORT_W  = 20;
    localparam int CNT_W   = 24;

    localparam int POS_DEMAND = 19;
    localparam int POS_IDX    = 17;
    localparam int POS_LAYER  = 12;
    localparam int POS_CRC    = 8;
    localparam int POS_SYNC   = 4;
    localparam int POS_SFREQ  = 2;
    localparam int POS_DEEMPH = 0;

    typedef enum logic [0:0] {
        MODE_BOOT = 1'b0,
        MODE_HOST = 1'b1
    } port_mode_e;

    typedef struct packed {
        logic [1:0] mpeg_idx;
        logic [1:0] layer;
        logic       crc_err;
        logic [1:0] sfreq;
        logic [1:0] deemph;
    } hdr_fields_t;

    localparam hdr_fields_t HDR_RESET = '{mpeg_idx: 2'b00, layer: 2'b00,
                                          crc_err: 1'b0, sfreq: 2'b00,
                                          deemph: 2'b00};

    function automatic logic [PORT_W-1:0] pack_word(input hdr_fields_t f,
                                                    input logic demand,
                                                    input logic sync);
        logic [PORT_W-1:0] w;
        w = '0;
        w[POS_DEMAND]          = demand;
        w[POS_IDX+1:POS_IDX]     = f.mpeg_idx;
        w[POS_LAYER+1:POS_LAYER] = f.layer;
        w[POS_CRC]             = f.crc_err;
        w[POS_SYNC]            = sync;
        w[POS_SFREQ+1:POS_SFREQ] = f.sfreq;
        w[POS_DEEMPH+1:POS_DEEMPH] = f.deemph;
        return w;
    endfunction

    function automatic logic [PORT_W-1:0] used_mask();
        hdr_fields_t ones;
        ones = '1;
        return pack_word(ones, 1'b1, 1'b1);
    endfunction

endpackage

// File: rtl/dec_status_capture.sv
module dec_status_capture
    import dec_status_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hdr_done_i,
    input  logic        demand_i,
    input  hdr_fields_t fields_i,
    output hdr_fields_t fields_q,
    output logic        demand_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fields_q <= HDR_RESET;
            demand_q <= 1'b0;
        end else begin
            demand_q <= demand_i;
            if (hdr_done_i) begin
                fields_q <= fields_i;
            end
        end
    end

endmodule

// File: rtl/dec_sync_flag.sv
module dec_sync_flag (
    input  logic clk,
    input  logic rst,
    input  logic hdr_done_i,
    input  logic rd_cmd_i,
    output logic sync_q,
    output logic overrun_q
);

    logic set_now;
    logic clr_now;
    logic lost_now;

    always_comb begin
        set_now  = hdr_done_i;
        clr_now  = rd_cmd_i && !hdr_done_i;
        lost_now = hdr_done_i && sync_q && !rd_cmd_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q    <= 1'b0;
            overrun_q <= 1'b0;
        end else begin
            if (set_now) begin
                sync_q <= 1'b1;
            end else if (clr_now) begin
                sync_q <= 1'b0;
            end
            if (lost_now) begin
                overrun_q <= 1'b1;
            end else if (rd_cmd_i) begin
                overrun_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dec_read_watchdog.sv
module dec_read_watchdog #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             late_q
);

    logic [CNT_W-1:0] count_q;
    logic             armed_q;
    logic [CNT_W-1:0] count_nx;

    always_comb begin
        count_nx = count_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            armed_q <= 1'b0;
            late_q  <= 1'b0;
        end else begin
            late_q <= 1'b0;
            if (start_i) begin
                count_q <= '0;
                armed_q <= 1'b1;
            end else if (stop_i) begin
                armed_q <= 1'b0;
            end else if (armed_q) begin
                count_q <= count_nx;
                if (count_nx == limit_i) begin
                    late_q  <= 1'b1;
                    armed_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/dec_port_drive.sv
module dec_port_drive
    import dec_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_done_i,
    input  logic              req_i,
    input  logic              cs_n_i,
    input  logic [PORT_W-1:0] word_i,
    output logic [PORT_W-1:0] port_o,
    output logic              oe_o
);

    port_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_BOOT;
        end else if (cfg_done_i) begin
            mode_q <= MODE_HOST;
        end
    end

    always_comb begin
        oe_o = (mode_q == MODE_HOST) && req_i && !cs_n_i;
    end

    for (genvar b = 0; b < PORT_W; b++) begin : g_bit
        assign port_o[b] = oe_o ? word_i[b] : 1'b0;
    end

endmodule

// File: rtl/dec_status_port.sv
module dec_status_port
    import dec_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_done_i,
    input  logic              req_i,
    input  logic              cs_n_i,
    input  logic              hdr_done_i,
    input  logic              demand_i,
    input  logic [1:0]        mpeg_idx_i,
    input  logic [1:0]        layer_i,
    input  logic              crc_err_i,
    input  logic [1:0]        sfreq_i,
    input  logic [1:0]        deemph_i,
    input  logic              rd_cmd_i,
    input  logic [CNT_W-1:0]  half_frame_i,
    output logic [PORT_W-1:0] port_o,
    output logic              port_oe_o,
    output logic              late_rd_o,
    output logic              overrun_o
);

    hdr_fields_t       fields_in;
    hdr_fields_t       fields_q;
    logic              demand_q;
    logic              sync_q;
    logic [PORT_W-1:0] word;

    always_comb begin
        fields_in.mpeg_idx = mpeg_idx_i;
        fields_in.layer    = layer_i;
        fields_in.crc_err  = crc_err_i;
        fields_in.sfreq    = sfreq_i;
        fields_in.deemph   = deemph_i;
    end

    dec_status_capture u_capture (
        .clk        (clk),
        .rst        (rst),
        .hdr_done_i (hdr_done_i),
        .demand_i   (demand_i),
        .fields_i   (fields_in),
        .fields_q   (fields_q),
        .demand_q   (demand_q)
    );

    dec_sync_flag u_sync (
        .clk        (clk),
        .rst        (rst),
        .hdr_done_i (hdr_done_i),
        .rd_cmd_i   (rd_cmd_i),
        .sync_q     (sync_q),
        .overrun_q  (overrun_o)
    );

    dec_read_watchdog #(.CNT_W(CNT_W)) u_wdog (
        .clk     (clk),
        .rst     (rst),
        .start_i (hdr_done_i),
        .stop_i  (rd_cmd_i),
        .limit_i (half_frame_i),
        .late_q  (late_rd_o)
    );

    always_comb begin
        word = pack_word(fields_q, demand_q, sync_q);
    end

    dec_port_drive u_drive (
        .clk        (clk),
        .rst        (rst),
        .cfg_done_i (cfg_done_i),
        .req_i      (req_i),
        .cs_n_i     (cs_n_i),
        .word_i     (word),
        .port_o     (port_o),
        .oe_o       (port_oe_o)
    );

endmodule

// File: rtl/dec_status_port_chk.sv
module dec_status_port_chk
    import dec_status_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_i,
    input logic              cs_n_i,
    input logic              hdr_done_i,
    input logic              rd_cmd_i,
    input logic [PORT_W-1:0] port_o,
    input logic              port_oe_o,
    input logic              late_rd_o,
    input logic              overrun_o,
    input logic              sync_q,
    input hdr_fields_t       fields_q
);

    // R2
    oe_needs_host_chk: assert property (@(posedge clk) disable iff (rst)
        port_oe_o |-> (req_i && !cs_n_i));

    // R2
    idle_port_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !port_oe_o |-> (port_o == '0));

    // R10
    spare_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (port_o & ~used_mask()) == '0);

    // R6
    sync_sets_chk: assert property (@(posedge clk) disable iff (rst)
        hdr_done_i |=> sync_q);

    // R6
    sync_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_cmd_i && !hdr_done_i) |=> !sync_q);

    // R4
    fields_held_chk: assert property (@(posedge clk) disable iff (rst)
        !hdr_done_i |=> $stable(fields_q));

    // R7
    late_single_chk: assert property (@(posedge clk) disable iff (rst)
        late_rd_o |=> !late_rd_o);

    // R8
    late_only_unread_chk: assert property (@(posedge clk) disable iff (rst)
        late_rd_o |-> sync_q);

    // R9
    overrun_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (hdr_done_i && sync_q && !rd_cmd_i) |=> overrun_o);

endmodule

bind dec_status_port dec_status_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .cs_n_i     (cs_n_i),
    .hdr_done_i (hdr_done_i),
    .rd_cmd_i   (rd_cmd_i),
    .port_o     (port_o),
    .port_oe_o  (port_oe_o),
    .late_rd_o  (late_rd_o),
    .overrun_o  (overrun_o),
    .sync_q     (sync_q),
    .fields_q   (fields_q)
);

// File: tb/dec_status_port_tb.sv
module dec_status_port_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_done_i, req_i, cs_n_i, hdr_done_i, demand_i, crc_err_i, rd_cmd_i;
    logic [1:0]  mpeg_idx_i, layer_i, sfreq_i, deemph_i;
    logic [23:0] half_frame_i;
    logic [19:0] port_o;
    logic        port_oe_o, late_rd_o, overrun_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    dec_status_port u_dut (
        .clk(clk), .rst(rst), .cfg_done_i(cfg_done_i), .req_i(req_i),
        .cs_n_i(cs_n_i), .hdr_done_i(hdr_done_i), .demand_i(demand_i),
        .mpeg_idx_i(mpeg_idx_i), .layer_i(layer_i), .crc_err_i(crc_err_i),
        .sfreq_i(sfreq_i), .deemph_i(deemph_i), .rd_cmd_i(rd_cmd_i),
        .half_frame_i(half_frame_i), .port_o(port_o), .port_oe_o(port_oe_o),
        .late_rd_o(late_rd_o), .overrun_o(overrun_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] exp_word(input logic dem, input logic [1:0] idx,
                                             input logic [1:0] lay, input logic crc,
                                             input logic sync, input logic [1:0] sf,
                                             input logic [1:0] de);
        logic [19:0] w = '0;
        w[19] = dem; w[18:17] = idx; w[13:12] = lay; w[8] = crc;
        w[4] = sync; w[3:2] = sf; w[1:0] = de;
        return w;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_hdr(input logic [1:0] idx, input logic [1:0] lay, input logic crc,
                             input logic [1:0] sf, input logic [1:0] de);
        mpeg_idx_i = idx; layer_i = lay; crc_err_i = crc; sfreq_i = sf; deemph_i = de;
        hdr_done_i = 1'b1;
        step();
        hdr_done_i = 1'b0;
    endtask

    task automatic pulse_rd();
        rd_cmd_i = 1'b1;
        step();
        rd_cmd_i = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cfg_done_i = 0; req_i = 1; cs_n_i = 0; hdr_done_i = 0; demand_i = 0;
        mpeg_idx_i = 0; layer_i = 0; crc_err_i = 0; sfreq_i = 0; deemph_i = 0;
        rd_cmd_i = 0; half_frame_i = 24'd5;
        @(negedge clk);
        step(); step();
        check("R1 oe in reset", {31'b0, port_oe_o}, 32'd0);
        rst = 1'b0;
        step();
        check("R1 port after reset", {12'b0, port_o}, 32'd0);
        check("R1 late/overrun", {30'b0, late_rd_o, overrun_o}, 32'd0);
    endtask

    task automatic t_mode_gate();
        #1;
        check("R2 boot mode float", {31'b0, port_oe_o}, 32'd0);
        cfg_done_i = 1'b1;
        #1;
        check("R2 no enable before edge", {31'b0, port_oe_o}, 32'd0);
        step();
        cfg_done_i = 1'b0;
        check("R2 host mode enable", {31'b0, port_oe_o}, 32'd1);
        check("R1 sync clear after reset", {31'b0, port_o[4]}, 32'd0);
        step();
        check("R2 host mode sticky", {31'b0, port_oe_o}, 32'd1);
        req_i = 1'b0; #1;
        check("R2 req low floats", {31'b0, port_oe_o}, 32'd0);
        req_i = 1'b1; cs_n_i = 1'b1; #1;
        check("R2 cs high floats", {31'b0, port_oe_o}, 32'd0);
        demand_i = 1'b1; step();
        check("R2 floating port zero", {12'b0, port_o}, 32'd0);
        cs_n_i = 1'b0; demand_i = 1'b0; step();
    endtask

    task automatic t_fields();
        pulse_hdr(2'b11, 2'b01, 1'b1, 2'b10, 2'b11);
        check("R3 R4 pattern A", {12'b0, port_o},
              {12'b0, exp_word(0, 2'b11, 2'b01, 1, 1, 2'b10, 2'b11)});
        mpeg_idx_i = 2'b00; layer_i = 2'b10; crc_err_i = 0; sfreq_i = 2'b01; deemph_i = 2'b01;
        step(); step();
        check("R4 fields held", {12'b0, port_o},
              {12'b0, exp_word(0, 2'b11, 2'b01, 1, 1, 2'b10, 2'b11)});
        pulse_rd();
        pulse_hdr(2'b10, 2'b10, 1'b0, 2'b01, 2'b01);
        check("R3 R4 pattern B", {12'b0, port_o},
              {12'b0, exp_word(0, 2'b10, 2'b10, 0, 1, 2'b01, 2'b01)});
        pulse_rd();
        pulse_hdr(2'b00, 2'b11, 1'b1, 2'b11, 2'b10);
        check("R3 R10 pattern C", {12'b0, port_o},
              {12'b0, exp_word(0, 2'b00, 2'b11, 1, 1, 2'b11, 2'b10)});
        check("R10 spare bits", {12'b0, port_o & 20'h1_C_E_E_0}, 32'd0);
        pulse_rd();
    endtask

    task automatic t_demand();
        demand_i = 1'b1; #1;
        check("R5 demand latency", {31'b0, port_o[19]}, 32'd0);
        step();
        check("R5 demand set", {31'b0, port_o[19]}, 32'd1);
        demand_i = 1'b0; step();
        check("R5 demand clear", {31'b0, port_o[19]}, 32'd0);
    endtask

    task automatic t_sync();
        pulse_hdr(2'b11, 2'b10, 0, 0, 0);
        check("R6 flag set", {31'b0, port_o[4]}, 32'd1);
        step();
        check("R6 flag sticky", {31'b0, port_o[4]}, 32'd1);
        pulse_rd();
        check("R6 flag cleared by read", {31'b0, port_o[4]}, 32'd0);
        pulse_hdr(2'b11, 2'b10, 0, 0, 0);
        hdr_done_i = 1'b1; rd_cmd_i = 1'b1; step();
        hdr_done_i = 1'b0; rd_cmd_i = 1'b0;
        check("R6 set wins", {31'b0, port_o[4]}, 32'd1);
        check("R9 no overrun on simultaneous", {31'b0, overrun_o}, 32'd0);
        pulse_rd();
    endtask

    task automatic t_late();
        int hits = 0;
        half_frame_i = 24'd5;
        pulse_hdr(2'b11, 2'b01, 0, 0, 0);
        check("R7 no pulse at start", {31'b0, late_rd_o}, 32'd0);
        for (int k = 1; k <= 8; k++) begin
            step();
            if (late_rd_o) hits++;
            check("R7 late timing", {31'b0, late_rd_o}, {31'b0, (k == 5)});
        end
        check("R7 single pulse", hits, 32'd1);
        pulse_rd();
    endtask

    task automatic t_ontime();
        int hits = 0;
        half_frame_i = 24'd5;
        pulse_hdr(2'b11, 2'b01, 0, 0, 0);
        for (int k = 1; k <= 4; k++) step();
        rd_cmd_i = 1'b1; step(); rd_cmd_i = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (late_rd_o) hits++;
            step();
        end
        check("R8 read at window edge", hits, 32'd0);
        check("R8 flag cleared", {31'b0, port_o[4]}, 32'd0);
    endtask

    task automatic t_overrun();
        check("R9 overrun idle", {31'b0, overrun_o}, 32'd0);
        pulse_hdr(2'b11, 2'b01, 0, 0, 0);
        pulse_hdr(2'b11, 2'b01, 0, 0, 0);
        check("R9 overrun set", {31'b0, overrun_o}, 32'd1);
        step(); step();
        check("R9 overrun sticky", {31'b0, overrun_o}, 32'd1);
        pulse_rd();
        check("R9 overrun cleared", {31'b0, overrun_o}, 32'd0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_mode_gate();
                t_fields();
                t_demand();
                t_sync();
                t_late();
                t_ontime();
                t_overrun();
            end
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule